// File: doc/BRIEF.md
# Bus-Mapped Parallel Output Latch

This block gives a multiplexed 16-bit address/data bus an 8-bit output register at one fixed port address, set by a parameter. In the low phase of the bus strobe E the shared lines carry the address. In the high phase they carry data: the upper lane (bits 15..8) holds the even byte of the word and the lower lane (bits 7..0) holds the odd byte. A lower-lane strobe, active low, works with address bit 0 to tell which bytes a cycle touches.

All bus pins are sampled in the system clock domain. The block keeps the address seen during E low. It keeps the data, the direction and the lane strobe seen during E high. When it sees E fall, it commits the byte from the lane that matches the port's address parity, but only if the cycle was a write to the port's word and the decode enables that lane. Between writes the output holds its value with no gaps.

Top module: `pbus_out_latch`

## Requirements
- R1: While rst_n is low the output q_o is 0x00, and it stays 0x00 until a qualifying write.
- R2: A port with an even address (PORT_ADDR bit 0 = 0) loads bits 15..8 of the data phase on an 8-bit write with address bit 0 = 0 and lane_lo_n_i = 1.
- R3: A port with an odd address loads bits 7..0 of the data phase on an 8-bit write with address bit 0 = 1 and lane_lo_n_i = 0.
- R4: A 16-bit write (address bit 0 = 0, lane_lo_n_i = 0) to the port's word updates the port, from bits 15..8 at an even address and from bits 7..0 at an odd address.
- R5: An 8-bit write to the neighbouring byte of the same word leaves q_o unchanged. For an even port that is bit 0 = 1 with lane_lo_n_i = 0. For an odd port that is bit 0 = 0 with lane_lo_n_i = 1.
- R6: A cycle with rnw_i = 1 (read) never changes q_o.
- R7: A write whose address bits 15..1 differ from those of PORT_ADDR leaves q_o unchanged.
- R8: q_o changes only at the second rising clock edge after e_i falls. It is unchanged after the first edge and at all other times.
- R9: The address is the last value of ad_i sampled while e_i is low. The data is the last value sampled while e_i is high. A new address placed on ad_i as e_i falls does not affect the write that is completing.
- R10: The combination address bit 0 = 1 with lane_lo_n_i = 1 never updates q_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ad_i | input | 16 | Multiplexed address/data lines |
| e_i | input | 1 | Bus phase strobe: low = address, high = data |
| rnw_i | input | 1 | 1 = read, 0 = write |
| lane_lo_n_i | input | 1 | Active-low strobe for the odd (lower) byte lane |
| q_o | output | 8 | Latched output byte |

## Verification
Two things happen in the same clock cycle. A write commits on the falling E edge, and in that very cycle the address latch starts loading the next cycle's address. The bench provokes this by putting a different, often matching, address on the lines at the exact moment E falls, and then checking that only the completed cycle's address and data decided the result. It also checks the output one edge before the commit and again at the commit, which tests the exact cycle of the update against a model computed in the bench.

// File: rtl/pbus_out_pkg.sv
package pbus_out_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic [BUS_W-1:0] addr;
    logic [BUS_W-1:0] data;
    logic             rnw;
    logic             lo_n;
  } bus_xfer_t;
endpackage

// File: rtl/pbus_sampler.sv
module pbus_sampler #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ad_i,
  input  logic         e_i,
  input  logic         rnw_i,
  input  logic         lo_n_i,
  output logic [W-1:0] ad_s,
  output logic         e_s,
  output logic         rnw_s,
  output logic         lo_n_s,
  output logic         e_fall
);
  logic e_d;
  logic [W-1:0] ad_n;
  logic e_n, rnw_n, lo_n_n;

  always_comb begin
    ad_n   = ad_i;
    e_n    = e_i;
    rnw_n  = rnw_i;
    lo_n_n = lo_n_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ad_s   <= '0;
      e_s    <= 1'b0;
      rnw_s  <= 1'b1;
      lo_n_s <= 1'b1;
      e_d    <= 1'b0;
    end else begin
      ad_s   <= ad_n;
      e_s    <= e_n;
      rnw_s  <= rnw_n;
      lo_n_s <= lo_n_n;
      e_d    <= e_s;
    end
  end

  assign e_fall = e_d & ~e_s;
endmodule

// File: rtl/pbus_phase_latch.sv
module pbus_phase_latch
  import pbus_out_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] ad_s,
  input  logic             e_s,
  input  logic             rnw_s,
  input  logic             lo_n_s,
  output bus_xfer_t        xfer
);
  bus_xfer_t xfer_n;
  logic      addr_en, data_en;

  always_comb begin
    addr_en = ~e_s;
    data_en = e_s;
    xfer_n  = xfer;
    if (addr_en) xfer_n.addr = ad_s;
    if (data_en) begin
      xfer_n.data = ad_s;
      xfer_n.rnw  = rnw_s;
      xfer_n.lo_n = lo_n_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer.addr <= '0;
      xfer.data <= '0;
      xfer.rnw  <= 1'b1;
      xfer.lo_n <= 1'b1;
    end else begin
      xfer <= xfer_n;
    end
  end

  AST_ADDR_FROZEN_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (e_s && $past(e_s)) |=> $stable(xfer.addr)) else $error("addr moved in data phase"); // R9
endmodule

// File: rtl/pbus_lane_decode.sv
module pbus_lane_decode
  import pbus_out_pkg::*;
#(
  parameter logic [BUS_W-1:0] PORT_ADDR = 16'h4000
) (
  input  bus_xfer_t         xfer,
  output logic              wr_hit,
  output logic [BYTE_W-1:0] wr_byte
);
  logic word_match;
  logic lane_on;

  assign word_match = (xfer.addr[BUS_W-1:1] == PORT_ADDR[BUS_W-1:1]);

  generate
    if (PORT_ADDR[0]) begin : g_odd
      assign lane_on = ~xfer.lo_n;
      assign wr_byte = xfer.data[BYTE_W-1:0];
    end else begin : g_even
      assign lane_on = ~xfer.addr[0];
      assign wr_byte = xfer.data[BUS_W-1:BUS_W-BYTE_W];
    end
  endgenerate

  assign wr_hit = word_match & lane_on & ~xfer.rnw;

  always_comb begin
    AST_ILLEGAL_NO_HIT: assert (!(xfer.addr[0] && xfer.lo_n && wr_hit)) else $error("illegal decode hit"); // R10
  end
endmodule

// File: rtl/pbus_out_reg.sv
module pbus_out_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         commit,
  input  logic         rnw,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;
  logic         q_en;

  always_comb begin
    q_en = commit;
    q_n  = q_en ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end

  AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(q)) else $error("q changed without commit"); // R8
  AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rnw |=> $stable(q)) else $error("read changed q"); // R6
endmodule

// File: rtl/pbus_out_latch.sv
module pbus_out_latch
  import pbus_out_pkg::*;
#(
  parameter logic [15:0] PORT_ADDR = 16'h4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ad_i,
  input  logic        e_i,
  input  logic        rnw_i,
  input  logic        lane_lo_n_i,
  output logic [7:0]  q_o
);
  logic [BUS_W-1:0]  ad_s;
  logic              e_s, rnw_s, lo_n_s, e_fall;
  bus_xfer_t         xfer;
  logic              wr_hit;
  logic [BYTE_W-1:0] wr_byte;

  pbus_sampler #(.W(BUS_W)) u_smp (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .e_i(e_i), .rnw_i(rnw_i),
    .lo_n_i(lane_lo_n_i), .ad_s(ad_s), .e_s(e_s), .rnw_s(rnw_s),
    .lo_n_s(lo_n_s), .e_fall(e_fall)
  );

  pbus_phase_latch u_phl (
    .clk(clk), .rst_n(rst_n), .ad_s(ad_s), .e_s(e_s), .rnw_s(rnw_s),
    .lo_n_s(lo_n_s), .xfer(xfer)
  );

  pbus_lane_decode #(.PORT_ADDR(PORT_ADDR)) u_dec (
    .xfer(xfer), .wr_hit(wr_hit), .wr_byte(wr_byte)
  );

  pbus_out_reg #(.W(BYTE_W)) u_reg (
    .clk(clk), .rst_n(rst_n), .commit(e_fall & wr_hit), .rnw(xfer.rnw),
    .d(wr_byte), .q(q_o)
  );

  AST_WORD_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer.addr[15:1] != PORT_ADDR[15:1]) |=> $stable(q_o)) else $error("miss changed q"); // R7
endmodule

// File: tb/pbus_out_latch_tb.sv
module pbus_out_latch_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [15:0] EVEN_A = 16'h4000;
  localparam logic [15:0] ODD_A  = 16'h4001;

  logic clk = 1'b0;
  logic rst_n;
  logic [15:0] ad;
  logic e, rnw, lo_n;
  logic [7:0] q_even, q_odd;
  int n_chk = 0, n_fail = 0;
  logic [7:0] m_even, m_odd;

  always #(CLK_PERIOD/2) clk = ~clk;

  pbus_out_latch #(.PORT_ADDR(EVEN_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .e_i(e), .rnw_i(rnw),
    .lane_lo_n_i(lo_n), .q_o(q_even));
  pbus_out_latch #(.PORT_ADDR(ODD_A)) dut_odd_i (
    .clk(clk), .rst_n(rst_n), .ad_i(ad), .e_i(e), .rnw_i(rnw),
    .lane_lo_n_i(lo_n), .q_o(q_odd));

  function automatic logic [7:0] model(input logic [15:0] port, input logic [15:0] a,
      input logic r, input logic ln, input logic [15:0] d, input logic [7:0] old);
    logic hit;
    hit = !r && (a[15:1] == port[15:1]) && (port[0] ? !ln : !a[0]);
    return hit ? (port[0] ? d[7:0] : d[15:8]) : old;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic [15:0] a, input logic r, input logic ln,
      input logic [15:0] d, input logic [15:0] next_a, input string req);
    logic [7:0] ne, no;
    @(negedge clk); e = 1'b0; ad = a; rnw = r; lo_n = ln;
    repeat (3) @(negedge clk);
    e = 1'b1; ad = d;
    repeat (3) @(negedge clk);
    e = 1'b0; ad = next_a;
    ne = model(EVEN_A, a, r, ln, d, m_even);
    no = model(ODD_A,  a, r, ln, d, m_odd);
    @(negedge clk);
    check({req, " R8 pre-commit even"}, q_even, m_even);
    check({req, " R8 pre-commit odd"},  q_odd,  m_odd);
    @(negedge clk);
    m_even = ne; m_odd = no;
    check({req, " even"}, q_even, m_even);
    check({req, " odd"},  q_odd,  m_odd);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; ad = 16'h0; e = 1'b0; rnw = 1'b1; lo_n = 1'b1;
    m_even = 8'h00; m_odd = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset even", q_even, 8'h00);
    check("R1 reset odd",  q_odd,  8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", q_even, 8'h00);

    bus_cycle(16'h4000, 1'b0, 1'b1, 16'hA55A, 16'h0000, "R2 8-bit even");
    bus_cycle(16'h4001, 1'b0, 1'b0, 16'h3C96, 16'h0000, "R3 8-bit odd");
    bus_cycle(16'h4000, 1'b0, 1'b0, 16'h1234, 16'h0000, "R4 16-bit");
    bus_cycle(16'h4001, 1'b0, 1'b0, 16'hFFEE, 16'h0000, "R5 neighbour of even");
    bus_cycle(16'h4000, 1'b0, 1'b1, 16'h77DD, 16'h0000, "R5 neighbour of odd");
    bus_cycle(16'h4000, 1'b1, 1'b0, 16'hBEEF, 16'h0000, "R6 read");
    bus_cycle(16'h4002, 1'b0, 1'b0, 16'hC0DE, 16'h0000, "R7 miss");
    bus_cycle(16'h4001, 1'b0, 1'b1, 16'h9999, 16'h0000, "R10 illegal");
    bus_cycle(16'h5000, 1'b0, 1'b0, 16'h6666, 16'h4000, "R9 next addr matches");
    bus_cycle(16'h4000, 1'b0, 1'b0, 16'h8181, 16'h4001, "R9 next addr after hit");

    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      logic [1:0] sel;
      sel = 2'($urandom_range(0, 3));
      a = (sel == 0) ? EVEN_A : (sel == 1) ? ODD_A : (sel == 2) ? 16'h4002 : 16'($urandom);
      bus_cycle(a, 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom), "R2/R3/R4/R6/R9 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule